// File: doc/BRIEF.md
# IO Page-Table Cache Invalidation Engine

This block clears cached copies of IO page-table entries after software has rewritten them in memory. Software writes a single 64-bit command word. The word carries three things: how many consecutive entries to drop, the byte address of the first of those entries, and a busy flag. Once the command is accepted, the engine walks the entry addresses one per cycle. Each address advances by 8 bytes. At every step the address is compared against a small store of cached entry addresses, and any matching slot loses its valid bit.

While the walk runs, bit 0 of the command register reads back as 1. Software polls that bit and issues the next chunk of a long run only after the bit has cleared. The translation side loads the tag store through a fill port, which names a slot and an entry address. The valid bits of all slots are visible at the ports.

Top module: `pte_inval_engine`

## Requirements
- R1: After reset, `busy` is 0, `cmd_rdata` is all zeros and every bit of `tag_valid` is 0.
- R2: A write (`cmd_we`=1) accepted while idle, with bit 0 set, raises `busy` in the cycle after the write edge. The start address is taken from bits 41:3 and the entry count from bits 63:53 of the written word.
- R3: With an entry count N, `busy` stays high for exactly max(N,1) clock cycles, counted from the write edge.
- R4: The walk visits entry addresses S, S+8, …, S+8·(N−1), where S is the programmed start address. Any valid slot whose address matches one of these on bits 41:3 is cleared. Bits 2:0 of a cached address take no part in the compare. Slots that do not match keep their valid bit.
- R5: A count of zero clears no slot, and `busy` drops one cycle after the write edge.
- R6: A write that arrives while `busy` is high has no effect. The read value stays the same, and the walk in progress keeps its length and its addresses.
- R7: A write accepted while idle with bit 0 clear stores the word but starts no walk. `busy` stays 0 and no slot is cleared.
- R8: `cmd_rdata` returns bits 63:1 of the last accepted command word, with bit 0 showing the live busy state.
- R9: `fill_en` loads `fill_addr` into slot `fill_slot` and sets that slot's valid bit in the next cycle. If a fill and a clear hit the same slot in the same cycle, the fill wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 64 | Command word being written |
| cmd_rdata | output | 64 | Command register read value, with bit 0 showing busy |
| busy | output | 1 | High while a walk is in progress |
| fill_en | input | 1 | Load one tag slot |
| fill_slot | input | $clog2(NUM_TAGS) | Slot index for a fill |
| fill_addr | input | 42 | Byte address of the cached entry |
| tag_valid | output | NUM_TAGS | Valid bit of each tag slot |

## Verification
The bench builds the block with its default of 16 tag slots and the full 11-bit count field. With that size, every slot can be placed relative to a walk window in one run. The tags are spread two entries apart, and the bench sweeps every start offset from 0 to 5 against every count from 0 to 24. This covers windows that hit no slot, part of the slots and the edge slots, and it gives the zero-count case. A separate run uses the largest count, 2047, to check the long busy interval and the far end of the address walk. Writes issued in the middle of a walk, and idle writes with the flag clear, cover the paths where a write is ignored or only stored.

// File: rtl/pie_pkg.sv
package pie_pkg;
    localparam int CMD_W   = 64;
    localparam int CNT_LSB = 53;
    localparam int CNT_W   = 11;
    localparam int ADR_LSB = 3;
    localparam int ADR_MSB = 41;
    localparam int ADR_W   = ADR_MSB - ADR_LSB + 1;

    typedef logic [ADR_W-1:0] entry_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic   busy;
        cnt_t   remain;
        entry_t cur;
    } walk_st_t;
endpackage

// File: rtl/pie_cmd_decode.sv
module pie_cmd_decode
    import pie_pkg::*;
(
    input  logic [CMD_W-1:0] word,
    output cnt_t             count,
    output entry_t           first_entry,
    output logic             go_flag
);
    always_comb begin
        count       = word[CNT_LSB +: CNT_W];
        first_entry = word[ADR_MSB:ADR_LSB];
        go_flag     = word[0];
    end
endmodule

// File: rtl/pie_walk_ctrl.sv
module pie_walk_ctrl
    import pie_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  cnt_t   start_cnt,
    input  entry_t start_entry,
    output logic   busy,
    output logic   step_en,
    output entry_t step_entry
);
    walk_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        step_en = 1'b0;
        if (st_q.busy) begin
            if (st_q.remain != '0) begin
                step_en     = 1'b1;
                st_d.cur    = st_q.cur + ADR_W'(1);
                st_d.remain = st_q.remain - CNT_W'(1);
                if (st_q.remain == CNT_W'(1)) st_d.busy = 1'b0;
            end else begin
                st_d.busy = 1'b0;
            end
        end else if (start) begin
            st_d.busy   = 1'b1;
            st_d.remain = start_cnt;
            st_d.cur    = start_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy       = st_q.busy;
    assign step_entry = st_q.cur;

    // R3
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(st_q.remain) <= CNT_W'(1)));

    // R5
    zero_cnt_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.remain == '0) |=> !busy);
endmodule

// File: rtl/pie_tag_store.sv
module pie_tag_store
    import pie_pkg::*;
#(
    parameter int NUM_TAGS = 16,
    localparam int SLOT_W  = $clog2(NUM_TAGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fill_en,
    input  logic [SLOT_W-1:0]   fill_slot,
    input  entry_t              fill_entry,
    input  logic                step_en,
    input  entry_t              step_entry,
    output logic [NUM_TAGS-1:0] valid
);
    entry_t              tag_d   [NUM_TAGS];
    entry_t              tag_q   [NUM_TAGS];
    logic [NUM_TAGS-1:0] valid_d, valid_q;
    logic [NUM_TAGS-1:0] hit;

    for (genvar i = 0; i < NUM_TAGS; i++) begin : g_cmp
        assign hit[i] = step_en && valid_q[i] && (tag_q[i] == step_entry);
    end

    always_comb begin
        tag_d   = tag_q;
        valid_d = valid_q & ~hit;
        if (fill_en) begin
            tag_d[fill_slot]   = fill_entry;
            valid_d[fill_slot] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_TAGS; i++) tag_q[i] <= '0;
            valid_q <= '0;
        end else begin
            tag_q   <= tag_d;
            valid_q <= valid_d;
        end
    end

    assign valid = valid_q;

    // R4
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !fill_en) |=> ($countones(valid) <= $countones($past(valid))));

    // R9
    fill_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> valid[$past(fill_slot)]);
endmodule

// File: rtl/pte_inval_engine.sv
module pte_inval_engine
    import pie_pkg::*;
#(
    parameter int NUM_TAGS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_we,
    input  logic [63:0]                  cmd_wdata,
    output logic [63:0]                  cmd_rdata,
    output logic                         busy,
    input  logic                         fill_en,
    input  logic [$clog2(NUM_TAGS)-1:0]  fill_slot,
    input  logic [41:0]                  fill_addr,
    output logic [NUM_TAGS-1:0]          tag_valid
);
    logic [CMD_W-1:0] cmd_d, cmd_q;
    logic             accept, start;
    cnt_t             dec_cnt;
    entry_t           dec_entry;
    logic             dec_go;
    logic             walk_busy, step_en;
    entry_t           step_entry;

    pie_cmd_decode u_dec (
        .word        (cmd_wdata),
        .count       (dec_cnt),
        .first_entry (dec_entry),
        .go_flag     (dec_go)
    );

    always_comb begin
        accept = cmd_we && !walk_busy;
        start  = accept && dec_go;
        cmd_d  = accept ? cmd_wdata : cmd_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    pie_walk_ctrl u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_cnt   (dec_cnt),
        .start_entry (dec_entry),
        .busy        (walk_busy),
        .step_en     (step_en),
        .step_entry  (step_entry)
    );

    pie_tag_store #(.NUM_TAGS(NUM_TAGS)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_en    (fill_en),
        .fill_slot  (fill_slot),
        .fill_entry (fill_addr[ADR_MSB:ADR_LSB]),
        .step_en    (step_en),
        .step_entry (step_entry),
        .valid      (tag_valid)
    );

    assign busy      = walk_busy;
    assign cmd_rdata = {cmd_q[CMD_W-1:1], walk_busy};

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_we && cmd_wdata[0]) |=> busy);

    // R6
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_we) |=> $stable(cmd_rdata[63:1]));

    // R7
    store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_we && !cmd_wdata[0]) |=> !busy);
endmodule

// File: tb/pte_inval_engine_bench.sv
`timescale 1ns/1ps
module pte_inval_engine_bench;
    localparam int NT = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_we = 1'b0;
    logic [63:0]   cmd_wdata = '0;
    logic [63:0]   cmd_rdata;
    logic          busy;
    logic          fill_en = 1'b0;
    logic [3:0]    fill_slot = '0;
    logic [41:0]   fill_addr = '0;
    logic [NT-1:0] tag_valid;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pte_inval_engine #(.NUM_TAGS(NT)) u_pte_inval_engine (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .busy(busy), .fill_en(fill_en),
        .fill_slot(fill_slot), .fill_addr(fill_addr), .tag_valid(tag_valid)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_word(input int n, input longint entry, input bit go);
        logic [63:0] w;
        w = (64'(n) << 53) | ((64'(entry) << 3) & 64'h0000_03FF_FFFF_FFF8) | 64'(go);
        return w;
    endfunction

    task automatic write_cmd(input logic [63:0] w);
        cmd_we = 1'b1; cmd_wdata = w;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic fill_slot_t(input int k, input longint entry);
        fill_en = 1'b1; fill_slot = 4'(k);
        fill_addr = 42'(entry << 3) | 42'(k % 8);
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // count cycles busy stays high, sampling at negedges after the write edge
    task automatic busy_len(output int len);
        len = 0;
        while (busy) begin
            len++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual %h expected %h", 64'd0, 64'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int len;
        logic [NT-1:0] exp_v;
        longint base;
        base = 64'h1000;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
        check(cmd_rdata == '0, "R1 rdata", cmd_rdata, 64'd0);
        check(tag_valid == '0, "R1 valid", 64'(tag_valid), 64'd0);

        // R9 fill
        fill_slot_t(5, 77);
        check(tag_valid == NT'(1 << 5), "R9 fill", 64'(tag_valid), 64'(1 << 5));

        // R4/R3/R5 sweep over start offset and count
        for (int off = 0; off <= 5; off++) begin
            for (int n = 0; n <= 24; n++) begin
                for (int k = 0; k < NT; k++) fill_slot_t(k, base + 2 * k);
                exp_v = '1;
                for (int k = 0; k < NT; k++)
                    if ((base + 2 * k) >= (base + off) && (base + 2 * k) < (base + off + n))
                        exp_v[k] = 1'b0;
                write_cmd(mk_word(n, base + off, 1'b1));
                // R2 busy raised, R8 readback
                check(busy == 1'b1, "R2 busy rise", 64'(busy), 64'd1);
                check(cmd_rdata == mk_word(n, base + off, 1'b1), "R8 readback busy",
                      cmd_rdata, mk_word(n, base + off, 1'b1));
                busy_len(len);
                if (n == 0) begin
                    check(len == 1, "R5 zero count busy", 64'(len), 64'd1);
                    check(tag_valid == '1, "R5 zero count clears none", 64'(tag_valid), 64'hFFFF);
                end else begin
                    check(len == n, "R3 busy length", 64'(len), 64'(n));
                end
                check(tag_valid == exp_v, "R4 cleared set", 64'(tag_valid), 64'(exp_v));
                check(cmd_rdata == mk_word(n, base + off, 1'b0), "R8 readback idle",
                      cmd_rdata, mk_word(n, base + off, 1'b0));
            end
        end

        // R6 write during busy is ignored
        for (int k = 0; k < NT; k++) fill_slot_t(k, base + 2 * k);
        write_cmd(mk_word(6, base, 1'b1));
        write_cmd(mk_word(20, base + 1, 1'b1));
        check(cmd_rdata == mk_word(6, base, 1'b1), "R6 rdata kept", cmd_rdata,
              mk_word(6, base, 1'b1));
        busy_len(len);
        check(len == 5, "R6 length kept", 64'(len), 64'd5);
        check(tag_valid == 16'hFFF8, "R6 walk kept", 64'(tag_valid), 64'hFFF8);

        // R7 idle write with flag clear stores only
        for (int k = 0; k < NT; k++) fill_slot_t(k, base + 2 * k);
        write_cmd(mk_word(10, base, 1'b0));
        check(busy == 1'b0, "R7 no busy", 64'(busy), 64'd0);
        @(negedge clk); @(negedge clk);
        check(tag_valid == '1, "R7 no clear", 64'(tag_valid), 64'hFFFF);
        check(cmd_rdata == mk_word(10, base, 1'b0), "R7 stored", cmd_rdata,
              mk_word(10, base, 1'b0));

        // R3/R4 largest count
        for (int k = 0; k < NT; k++) fill_slot_t(k, base + 200 * k);
        write_cmd(mk_word(2047, base, 1'b1));
        busy_len(len);
        check(len == 2047, "R3 max length", 64'(len), 64'd2047);
        check(tag_valid == 16'hF800, "R4 max walk", 64'(tag_valid), 64'hF800);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule